// File: doc/BRIEF.md
# Banked Processor Register Set

This block holds the architectural register state of a small 16-bit processor core. It has two banks of general registers, where each bank holds four data registers, two address registers and a frame base. It also has a shared static base register, a user stack pointer and an interrupt stack pointer, a 20-bit program counter, a 20-bit interrupt table base and an 11-bit flag word. Decode logic reads the registers through two combinational read ports and writes them through one write port. Both kinds of port take a 4-bit register number. The ALU reports its status on a separate input, and a request line lets the block accept a maskable interrupt.

Two flag bits steer every access. The bank bit selects which copy of the banked registers the register numbers reach. The stack-select bit decides whether the stack pointer alias reaches the user or the interrupt pointer. Accepting an interrupt clears the interrupt-enable bit. The block only stores, selects and updates state. Instruction decode, the arithmetic itself, memory traffic and vector fetch belong to other blocks.

Top module: `rf_regset`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, all registers and `flags` read 0. So bank 0 and the interrupt stack pointer are selected, and `irq_accept` is 0.
- R2: Register numbers 0–3 (data), 4 (address low), 5 (address high), 6 (frame base) and 7 (static base) store `wr_data[15:0]`. A read returns the value zero-extended to 32 bits.
- R3: Flag bit 4 selects the bank for register numbers 0–6: 0 selects bank 0 and 1 selects bank 1. Number 7 and all other numbers reach the same storage in either bank.
- R4: Number 8 is the stack pointer alias. It reaches the interrupt pointer when flag bit 7 is 0 and the user pointer when it is 1. Number 9 always reaches the user pointer and number 10 always reaches the interrupt pointer. All three numbers move 16 bits.
- R5: Number 14 treats numbers 5 and 4 of the current bank as one 32-bit register. A read returns {reg5, reg4}, and a write stores `wr_data[31:16]` into 5 and `wr_data[15:0]` into 4.
- R6: Number 11 (program counter) and number 12 (interrupt table base) store `wr_data[19:0]` and read back zero-extended.
- R7: When `alu_upd` is 1, the next flags take carry (bit 0) from `alu_carry`, zero (bit 2) = (`alu_res`==0), sign (bit 3) = `alu_res[15]` and overflow (bit 5) from `alu_ovf`. On these four bits this takes precedence over a write to number 13. Other bits are unchanged by the ALU path.
- R8: The debug flag (bit 1) always reads 0. A write that sets it is ignored.
- R9: `irq_accept` = `irq_req` AND flag bit 6 (interrupt enable). When it is 1, bit 6 is 0 after the edge, even if number 13 is written in the same cycle.
- R10: Reads are combinational from the stored state. A write to number 13 loads `wr_data[10:0]` into the flags. A write, and any bank or stack-select change, becomes visible only after the next rising edge.
- R11: Number 15 always reads 0, and writing it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number written |
| wr_data | input | 32 | Write data |
| alu_upd | input | 1 | Apply ALU status to the flags |
| alu_res | input | 16 | ALU result used for zero and sign |
| alu_carry | input | 1 | Carry, borrow or shifted-out bit |
| alu_ovf | input | 1 | Arithmetic overflow |
| irq_req | input | 1 | Maskable interrupt request |
| irq_accept | output | 1 | Request accepted this cycle |
| flags | output | 11 | Current flag word |

## Verification
Directed sequences write the same register number under both bank settings and read it back after each switch. This separates correct bank steering from storage that ignores the bank bit. The stack alias is written with each stack-select value and then read through the direct numbers 9 and 10, which shows which pointer was actually touched. Same-cycle collisions cover a flag write together with the ALU path and a flag write together with interrupt acceptance, and they expose a wrong priority order. Long random traffic mixes every register number, random flag words that flip bank and stack select, ALU updates and requests. The traffic is compared every cycle against a bench model of both banks.

// File: rtl/rf_regset_pkg.sv
`timescale 1ns/1ps
package rf_regset_pkg;

    // Architectural register numbers seen on the read and write ports.
    typedef enum logic [3:0] {
        RIX_D0   = 4'd0,
        RIX_D1   = 4'd1,
        RIX_D2   = 4'd2,
        RIX_D3   = 4'd3,
        RIX_ADRL = 4'd4,
        RIX_ADRH = 4'd5,
        RIX_FRM  = 4'd6,
        RIX_STB  = 4'd7,
        RIX_SP   = 4'd8,
        RIX_USP  = 4'd9,
        RIX_ISP  = 4'd10,
        RIX_PC   = 4'd11,
        RIX_ITB  = 4'd12,
        RIX_FLG  = 4'd13,
        RIX_PAIR = 4'd14,
        RIX_NONE = 4'd15
    } reg_idx_e;

    localparam int IDX_W       = 4;
    localparam int BANKED_REGS = 7;   // numbers 0..6 live in each bank
    localparam int NUM_BANKS   = 2;   // one bank-select flag bit

    // Flag bit positions.
    localparam int FLG_C = 0;
    localparam int FLG_D = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_S = 3;
    localparam int FLG_B = 4;
    localparam int FLG_O = 5;
    localparam int FLG_I = 6;
    localparam int FLG_U = 7;

endpackage

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
    import rf_regset_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int FLAG_W = 11,
    parameter int NBREG  = 7
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NBREG-1:0][DATA_W-1:0]     bank_view,
    input  logic [DATA_W-1:0]                sb,
    input  logic [DATA_W-1:0]                usp,
    input  logic [DATA_W-1:0]                isp,
    input  logic [ADDR_W-1:0]                pc,
    input  logic [ADDR_W-1:0]                intb,
    input  logic [FLAG_W-1:0]                flg,
    output logic [2*DATA_W-1:0]              data
);
    localparam int RD_W = 2 * DATA_W;
    localparam int SEL_W = $clog2(NBREG);

    logic [SEL_W-1:0] bsel;
    assign bsel = idx[SEL_W-1:0];

    always_comb begin
        data = '0;
        case (reg_idx_e'(idx))
            RIX_D0, RIX_D1, RIX_D2, RIX_D3,
            RIX_ADRL, RIX_ADRH, RIX_FRM: data[DATA_W-1:0] = bank_view[bsel];
            RIX_STB:  data[DATA_W-1:0] = sb;
            RIX_SP:   data[DATA_W-1:0] = flg[FLG_U] ? usp : isp;
            RIX_USP:  data[DATA_W-1:0] = usp;
            RIX_ISP:  data[DATA_W-1:0] = isp;
            RIX_PC:   data[ADDR_W-1:0] = pc;
            RIX_ITB:  data[ADDR_W-1:0] = intb;
            RIX_FLG:  data[FLAG_W-1:0] = flg;
            RIX_PAIR: data[RD_W-1:0]   = {bank_view[RIX_ADRH], bank_view[RIX_ADRL]};
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/rf_flag_next.sv
`timescale 1ns/1ps
module rf_flag_next
    import rf_regset_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 11
) (
    input  logic [FLAG_W-1:0] flg_q,
    input  logic              wr_flg,
    input  logic [FLAG_W-1:0] wr_val,
    input  logic              alu_upd,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              irq_take,
    output logic [FLAG_W-1:0] flg_d
);
    always_comb begin
        flg_d = flg_q;
        // Lowest precedence: whole-word write through the write port.
        if (wr_flg) begin
            flg_d = wr_val;
        end
        // ALU status overrides the four result bits.
        if (alu_upd) begin
            flg_d[FLG_C] = alu_carry;
            flg_d[FLG_Z] = (alu_res == '0);
            flg_d[FLG_S] = alu_res[DATA_W-1];
            flg_d[FLG_O] = alu_ovf;
        end
        // Interrupt acceptance masks further requests.
        if (irq_take) begin
            flg_d[FLG_I] = 1'b0;
        end
        // Debug bit is never set by this block.
        flg_d[FLG_D] = 1'b0;
    end
endmodule

// File: rtl/rf_regset.sv
`timescale 1ns/1ps
module rf_regset
    import rf_regset_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int FLAG_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           rd_a_idx,
    input  logic [3:0]           rd_b_idx,
    output logic [2*DATA_W-1:0]  rd_a_data,
    output logic [2*DATA_W-1:0]  rd_b_data,
    input  logic                 wr_en,
    input  logic [3:0]           wr_idx,
    input  logic [2*DATA_W-1:0]  wr_data,
    input  logic                 alu_upd,
    input  logic [DATA_W-1:0]    alu_res,
    input  logic                 alu_carry,
    input  logic                 alu_ovf,
    input  logic                 irq_req,
    output logic                 irq_accept,
    output logic [FLAG_W-1:0]    flags
);
    localparam int RD_W   = 2 * DATA_W;
    localparam int NRD    = 2;
    localparam int NBREG  = BANKED_REGS;
    localparam int SEL_W  = $clog2(NBREG);

    typedef logic [NBREG-1:0][DATA_W-1:0] bank_t;

    typedef struct packed {
        logic [NUM_BANKS-1:0][NBREG-1:0][DATA_W-1:0] banks;
        logic [DATA_W-1:0] sb;
        logic [DATA_W-1:0] usp;
        logic [DATA_W-1:0] isp;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] intb;
        logic [FLAG_W-1:0] flg;
    } state_t;

    state_t state_q, state_d;

    // Current bank and stack selection, from registered flags only.
    logic  bank_sel_q;
    logic  stk_user_q;
    bank_t bank_view;
    assign bank_sel_q = state_q.flg[FLG_B];
    assign stk_user_q = state_q.flg[FLG_U];
    assign bank_view  = state_q.banks[bank_sel_q];

    // Interrupt acceptance gated by the enable flag.
    logic irq_take;
    assign irq_take   = irq_req & state_q.flg[FLG_I];
    assign irq_accept = irq_take;
    assign flags      = state_q.flg;

    // Read ports.
    logic [NRD-1:0][IDX_W-1:0] rd_idx_w;
    logic [NRD-1:0][RD_W-1:0]  rd_data_w;
    assign rd_idx_w  = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data_w[0];
    assign rd_b_data = rd_data_w[1];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_read_port #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .FLAG_W (FLAG_W),
            .NBREG  (NBREG)
        ) u_rd (
            .idx       (rd_idx_w[p]),
            .bank_view (bank_view),
            .sb        (state_q.sb),
            .usp       (state_q.usp),
            .isp       (state_q.isp),
            .pc        (state_q.pc),
            .intb      (state_q.intb),
            .flg       (state_q.flg),
            .data      (rd_data_w[p])
        );
    end

    // Flag next-state.
    logic              wr_flg;
    logic [FLAG_W-1:0] flg_next;
    assign wr_flg = wr_en && (reg_idx_e'(wr_idx) == RIX_FLG);

    rf_flag_next #(
        .DATA_W (DATA_W),
        .FLAG_W (FLAG_W)
    ) u_flg (
        .flg_q     (state_q.flg),
        .wr_flg    (wr_flg),
        .wr_val    (wr_data[FLAG_W-1:0]),
        .alu_upd   (alu_upd),
        .alu_res   (alu_res),
        .alu_carry (alu_carry),
        .alu_ovf   (alu_ovf),
        .irq_take  (irq_take),
        .flg_d     (flg_next)
    );

    logic [SEL_W-1:0] wsel;
    assign wsel = wr_idx[SEL_W-1:0];

    // Next-state computation.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (reg_idx_e'(wr_idx))
                RIX_D0, RIX_D1, RIX_D2, RIX_D3,
                RIX_ADRL, RIX_ADRH, RIX_FRM:
                    state_d.banks[bank_sel_q][wsel] = wr_data[DATA_W-1:0];
                RIX_STB: state_d.sb = wr_data[DATA_W-1:0];
                RIX_SP: begin
                    if (stk_user_q) state_d.usp = wr_data[DATA_W-1:0];
                    else            state_d.isp = wr_data[DATA_W-1:0];
                end
                RIX_USP: state_d.usp  = wr_data[DATA_W-1:0];
                RIX_ISP: state_d.isp  = wr_data[DATA_W-1:0];
                RIX_PC:  state_d.pc   = wr_data[ADDR_W-1:0];
                RIX_ITB: state_d.intb = wr_data[ADDR_W-1:0];
                RIX_PAIR: begin
                    state_d.banks[bank_sel_q][RIX_ADRL] = wr_data[DATA_W-1:0];
                    state_d.banks[bank_sel_q][RIX_ADRH] = wr_data[RD_W-1:DATA_W];
                end
                default: ;
            endcase
        end
        state_d.flg = flg_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/rf_regset_checker.sv
`timescale 1ns/1ps
module rf_regset_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic        alu_upd,
    input logic [15:0] alu_res,
    input logic        irq_req,
    input logic        irq_accept,
    input logic [10:0] flags
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags == 11'd0 && !irq_accept));

    assert_debug_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] == 1'b0);

    assert_accept_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_req && flags[6]));

    assert_accept_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !flags[6]);

    assert_alu_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alu_upd |=> (flags[2] == ($past(alu_res) == 16'd0)));

    assert_alu_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alu_upd |=> (flags[3] == $past(alu_res[15])));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !alu_upd && !irq_accept) |=> $stable(flags));

    assert_none_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'd15) |-> (rd_a_data == 32'd0));
endmodule

bind rf_regset rf_regset_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .wr_en      (wr_en),
    .alu_upd    (alu_upd),
    .alu_res    (alu_res),
    .irq_req    (irq_req),
    .irq_accept (irq_accept),
    .flags      (flags)
);

// File: tb/rf_regset_bench.sv
`timescale 1ns/1ps
module rf_regset_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, alu_upd = 1'b0, alu_carry = 1'b0, alu_ovf = 1'b0;
    logic [15:0] alu_res = '0;
    logic        irq_req = 1'b0, irq_accept;
    logic [10:0] flags;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    rf_regset u_rf_regset (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .alu_upd(alu_upd), .alu_res(alu_res), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .irq_req(irq_req), .irq_accept(irq_accept), .flags(flags)
    );

    // Reference model.
    logic [15:0] m_bank [2][7];
    logic [15:0] m_sb, m_usp, m_isp;
    logic [19:0] m_pc, m_intb;
    logic [10:0] m_flg;

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 7; r++) m_bank[b][r] = '0;
        m_sb = '0; m_usp = '0; m_isp = '0; m_pc = '0; m_intb = '0; m_flg = '0;
    endtask

    function automatic logic [31:0] mread(input logic [3:0] i);
        logic b;
        b = m_flg[4];
        case (i)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return {16'h0, m_bank[b][i[2:0]]};
            4'd7:  return {16'h0, m_sb};
            4'd8:  return {16'h0, (m_flg[7] ? m_usp : m_isp)};
            4'd9:  return {16'h0, m_usp};
            4'd10: return {16'h0, m_isp};
            4'd11: return {12'h0, m_pc};
            4'd12: return {12'h0, m_intb};
            4'd13: return {21'h0, m_flg};
            4'd14: return {m_bank[b][5], m_bank[b][4]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rq(input logic [3:0] i);
        if (i <= 4'd7) return "R3";
        if (i <= 4'd10) return "R4";
        if (i <= 4'd12) return "R6";
        if (i == 4'd13) return "R10";
        if (i == 4'd14) return "R5";
        return "R11";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_commit();
        logic b, u, acc;
        logic [10:0] nf;
        b = m_flg[4]; u = m_flg[7];
        acc = irq_req & m_flg[6];
        nf = m_flg;
        if (wr_en) begin
            case (wr_idx)
                4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: m_bank[b][wr_idx[2:0]] = wr_data[15:0];
                4'd7:  m_sb = wr_data[15:0];
                4'd8:  if (u) m_usp = wr_data[15:0]; else m_isp = wr_data[15:0];
                4'd9:  m_usp = wr_data[15:0];
                4'd10: m_isp = wr_data[15:0];
                4'd11: m_pc = wr_data[19:0];
                4'd12: m_intb = wr_data[19:0];
                4'd13: nf = wr_data[10:0];
                4'd14: begin m_bank[b][4] = wr_data[15:0]; m_bank[b][5] = wr_data[31:16]; end
                default: ;
            endcase
        end
        if (alu_upd) begin
            nf[0] = alu_carry; nf[2] = (alu_res == 16'h0); nf[3] = alu_res[15]; nf[5] = alu_ovf;
        end
        if (acc) nf[6] = 1'b0;
        nf[1] = 1'b0;
        m_flg = nf;
    endtask

    // Drive one cycle's inputs at the falling edge and check outputs against the model.
    task automatic drive(input logic [3:0] a, input logic [3:0] b,
                         input logic we, input logic [3:0] wi, input logic [31:0] wd,
                         input logic au, input logic [15:0] ar, input logic ac, input logic ao,
                         input logic irq);
        @(negedge clk);
        rd_a_idx = a; rd_b_idx = b;
        wr_en = we; wr_idx = wi; wr_data = wd;
        alu_upd = au; alu_res = ar; alu_carry = ac; alu_ovf = ao;
        irq_req = irq;
        #1;
        chk(rq(a), rd_a_data, mread(a));
        chk(rq(b), rd_b_data, mread(b));
        chk("R7", {21'h0, flags}, {21'h0, m_flg});
        chk("R9", {31'h0, irq_accept}, {31'h0, irq & m_flg[6]});
    endtask

    task automatic commit();
        @(posedge clk);
        model_commit();
    endtask

    task automatic idle(input logic [3:0] a, input logic [3:0] b);
        drive(a, b, 1'b0, 4'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        void'($urandom(32'd2024));
        // R1: state during reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_a_idx = 4'd14; rd_b_idx = 4'd8; irq_req = 1'b1;
        #1;
        chk("R1", rd_a_data, 32'h0);
        chk("R1", rd_b_data, 32'h0);
        chk("R1", {21'h0, flags}, 32'h0);
        chk("R1", {31'h0, irq_accept}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; irq_req = 1'b0;

        // R10: old value visible in the write cycle; R2: zero-extended readback.
        drive(4'd0, 4'd0, 1'b1, 4'd0, 32'hABCD_1234, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R10", rd_a_data, 32'h0);
        commit();
        drive(4'd0, 4'd7, 1'b1, 4'd13, 32'h0000_0010, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R2", rd_a_data, 32'h0000_1234);
        commit();
        // R3: bank 1 selected.
        drive(4'd0, 4'd0, 1'b1, 4'd0, 32'h0000_5555, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R3", rd_a_data, 32'h0);
        commit();
        drive(4'd0, 4'd0, 1'b1, 4'd13, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R3", rd_a_data, 32'h0000_5555);
        commit();
        idle(4'd0, 4'd0);
        chk("R3", rd_a_data, 32'h0000_1234);
        commit();

        // R4: stack alias.
        drive(4'd8, 4'd8, 1'b1, 4'd8, 32'h0000_1111, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        commit();
        drive(4'd10, 4'd9, 1'b1, 4'd13, 32'h0000_0080, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R4", rd_a_data, 32'h0000_1111);
        chk("R4", rd_b_data, 32'h0);
        commit();
        drive(4'd8, 4'd8, 1'b1, 4'd8, 32'h0000_2222, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R4", rd_a_data, 32'h0);
        commit();
        idle(4'd9, 4'd10);
        chk("R4", rd_a_data, 32'h0000_2222);
        chk("R4", rd_b_data, 32'h0000_1111);
        commit();

        // R5: address pair.
        drive(4'd14, 4'd14, 1'b1, 4'd14, 32'hDEAD_BEEF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        commit();
        idle(4'd4, 4'd5);
        chk("R5", rd_a_data, 32'h0000_BEEF);
        chk("R5", rd_b_data, 32'h0000_DEAD);
        commit();

        // R6: 20-bit program counter.
        drive(4'd11, 4'd12, 1'b1, 4'd11, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        commit();
        idle(4'd11, 4'd12);
        chk("R6", rd_a_data, 32'h000F_FFFF);
        commit();

        // R8: debug bit ignored.
        drive(4'd13, 4'd0, 1'b1, 4'd13, 32'h0000_07FF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        commit();
        drive(4'd13, 4'd0, 1'b1, 4'd13, 32'h0000_07FF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R8", {21'h0, flags}, 32'h0000_07FD);
        chk("R9", {31'h0, irq_accept}, 32'h1);
        commit();
        drive(4'd13, 4'd0, 1'b0, 4'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R9", {21'h0, flags}, 32'h0000_07BD);
        chk("R9", {31'h0, irq_accept}, 32'h0);
        commit();

        // R7: ALU overrides flag write on its bits.
        drive(4'd13, 4'd0, 1'b1, 4'd13, 32'h0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
        commit();
        drive(4'd13, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b0);
        chk("R7", {21'h0, flags}, 32'h0000_0005);
        commit();
        idle(4'd13, 4'd0);
        chk("R7", {21'h0, flags}, 32'h0000_0028);
        commit();

        // R11: number 15.
        drive(4'd15, 4'd15, 1'b1, 4'd15, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R11", rd_a_data, 32'h0);
        commit();

        // Constrained random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a, b, wi;
            logic [31:0] wd;
            logic we, au, irq;
            a  = 4'($urandom_range(0, 15));
            b  = 4'($urandom_range(0, 15));
            wi = 4'($urandom_range(0, 15));
            wd = $urandom;
            we = ($urandom_range(0, 3) != 0);
            au = ($urandom_range(0, 2) == 0);
            irq = ($urandom_range(0, 3) == 0);
            drive(a, b, we, wi, wd, au, 16'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                  1'($urandom), 1'($urandom), irq);
            commit();
        end
        idle(4'd0, 4'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule